// File: doc/BRIEF.md
# Cipher Extension Operand Bypass Network

This block sits in the decode stage of a processor that carries a block-cipher functional unit beside its integer pipeline. The cipher unit keeps its own small register file. Words 0 and 1 hold the 64-bit data block, with the high half in word 0. Words 2 to 5 hold the four 32-bit key words. The network delivers the newest value of each of these six words to the cipher unit, so that a round pair and its key derivation can start before earlier writes have retired.

Three integer stages (execute, memory, write-back) each present a bypass bus. A bus carries a 5-bit destination field, a 32-bit value and a 3-bit instruction-kind code. Only the two kinds that write the extension file take part in forwarding. Every other kind is invisible here. A flag from each stage also tells the integer forwarding logic that the destination is an extension register, so the integer logic must not treat it as a match.

A fourth bypass comes from the final step of the multicycle cipher datapath. It carries a freshly computed 64-bit block and a valid flag, and it replaces the stored data block. The block is purely combinational and holds no state.

Top module: `ext_fwd_unit`

## Requirements
- R1: When no bus carries a forwarding kind and `res_vld_i` is low, `blk_o` equals {stored word 0, stored word 1} and `key_o[32*k +: 32]` equals stored word 2+k, for k = 0..3.
- R2: Only kind code 1 (integer XOR integer into the extension file) and kind code 2 (integer XOR extension into the extension file) forward. Codes 0 and 3 to 7 leave every output unchanged.
- R3: The extension address of a bus is bits [3:0] of its 5-bit destination field. Bit 4 has no effect.
- R4: A forwarding bus whose address is 6 to 15 changes no output.
- R5: When several stages target the same word, the execute stage (bus slot 0) wins over memory (slot 1), which wins over write-back (slot 2), which wins over the stored value. This holds for the block words and the key words alike.
- R6: While `res_vld_i` is high, `blk_o` equals `res_blk_i` whatever the stage buses carry. The key words are unaffected by the result bypass.
- R7: `ext_dst_o[s]` is high exactly when bus s carries kind code 1 or 2, independent of its destination field and of `res_vld_i`.
- R8: All outputs follow their inputs within the same time step, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| st_regs_i | input | 192 | Stored extension words 0..5, word n at bits [32n+31:32n] |
| byp_dst_i | input | 15 | Destination fields of the three stage buses, slot s at [5s+4:5s] (0 = EX, 1 = MEM, 2 = WB) |
| byp_val_i | input | 96 | Values carried by the three stage buses |
| byp_kind_i | input | 9 | Instruction-kind codes of the three stage buses |
| res_vld_i | input | 1 | Cipher result bypass valid |
| res_blk_i | input | 64 | Cipher result block, high half destined for word 0 |
| blk_o | output | 64 | Newest data block for the next round pair |
| key_o | output | 128 | Newest key words, word 2+k at bits [32k+31:32k] |
| ext_dst_o | output | 3 | Per stage: destination lies in the extension file, so the integer match must be ignored |

## Verification
The checks assume that the surrounding pipeline never issues a block write while a round pair is in flight. Under that assumption a valid cipher result is always the newest value for words 0 and 1, and the fixed result-over-stage priority is correct. The stimulus honours this only where it matters: it combines the result flag with stage writes to words 0 and 1 only to show that those writes are overridden, never to model an older result. The bench sweeps every kind code and every destination field for each stage, then every combination of four kinds and six addresses across all three stages. Each output is compared against a model built from the priority rules.

// File: rtl/fwd_pkg.sv
`timescale 1ns/1ps
package fwd_pkg;

  localparam int KIND_W = 3;

  typedef enum logic [KIND_W-1:0] {
    KIND_IDLE    = 3'd0,
    KIND_XOR_II  = 3'd1,
    KIND_XOR_IE  = 3'd2,
    KIND_XOR_EI  = 3'd3,
    KIND_RNDPAIR = 3'd4
  } byp_kind_e;

  localparam int HI_IDX   = 0;
  localparam int LO_IDX   = 1;
  localparam int KEY_BASE = 2;

  function automatic logic writes_ext(input logic [KIND_W-1:0] kind);
    return (kind == KIND_XOR_II) || (kind == KIND_XOR_IE);
  endfunction

endpackage

// File: rtl/fwd_stage_decode.sv
`timescale 1ns/1ps
module fwd_stage_decode #(
  parameter int NUM_REGS = 6,
  parameter int DST_W    = 5,
  parameter int ADDR_W   = 4,
  parameter int KIND_W   = fwd_pkg::KIND_W
) (
  input  logic [DST_W-1:0]    dst_i,
  input  logic [KIND_W-1:0]   kind_i,
  output logic                ext_wr_o,
  output logic [NUM_REGS-1:0] hit_o
);

  logic [ADDR_W-1:0] addr;

  always_comb begin
    ext_wr_o = fwd_pkg::writes_ext(kind_i);
    addr     = dst_i[ADDR_W-1:0];
    for (int r = 0; r < NUM_REGS; r++) begin
      hit_o[r] = ext_wr_o && (addr == ADDR_W'(r));
    end
  end

endmodule

// File: rtl/fwd_word_pick.sv
`timescale 1ns/1ps
module fwd_word_pick #(
  parameter int WORD_W     = 32,
  parameter int NUM_STAGES = 3
) (
  input  logic [WORD_W-1:0]            stored_i,
  input  logic [NUM_STAGES-1:0]        hit_i,
  input  logic [NUM_STAGES*WORD_W-1:0] vals_i,
  output logic [WORD_W-1:0]            word_o
);

  // Oldest stage applied first, youngest last, so the youngest hit survives.
  always_comb begin
    word_o = stored_i;
    for (int s = NUM_STAGES - 1; s >= 0; s--) begin
      if (hit_i[s]) word_o = vals_i[s*WORD_W +: WORD_W];
    end
  end

endmodule

// File: rtl/fwd_blk_merge.sv
`timescale 1ns/1ps
module fwd_blk_merge #(
  parameter int WORD_W = 32
) (
  input  logic                res_vld_i,
  input  logic [2*WORD_W-1:0] res_blk_i,
  input  logic [WORD_W-1:0]   hi_i,
  input  logic [WORD_W-1:0]   lo_i,
  output logic [2*WORD_W-1:0] blk_o
);

  always_comb begin
    if (res_vld_i) blk_o = res_blk_i;
    else           blk_o = {hi_i, lo_i};
  end

endmodule

// File: rtl/ext_fwd_unit.sv
`timescale 1ns/1ps
module ext_fwd_unit #(
  parameter int WORD_W     = 32,
  parameter int NUM_STAGES = 3,
  parameter int NUM_REGS   = 6,
  parameter int DST_W      = 5,
  parameter int ADDR_W     = 4,
  parameter int KIND_W     = fwd_pkg::KIND_W
) (
  input  logic [NUM_REGS*WORD_W-1:0]     st_regs_i,
  input  logic [NUM_STAGES*DST_W-1:0]    byp_dst_i,
  input  logic [NUM_STAGES*WORD_W-1:0]   byp_val_i,
  input  logic [NUM_STAGES*KIND_W-1:0]   byp_kind_i,
  input  logic                           res_vld_i,
  input  logic [2*WORD_W-1:0]            res_blk_i,
  output logic [2*WORD_W-1:0]            blk_o,
  output logic [(NUM_REGS-2)*WORD_W-1:0] key_o,
  output logic [NUM_STAGES-1:0]          ext_dst_o
);

  localparam int NUM_KEY = NUM_REGS - fwd_pkg::KEY_BASE;

  logic [NUM_STAGES-1:0] stg_ext;
  logic [NUM_REGS-1:0]   stg_hit  [NUM_STAGES];
  logic [NUM_STAGES-1:0] reg_hit  [NUM_REGS];
  logic [WORD_W-1:0]     fwd_word [NUM_REGS];

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
    fwd_stage_decode #(
      .NUM_REGS (NUM_REGS),
      .DST_W    (DST_W),
      .ADDR_W   (ADDR_W),
      .KIND_W   (KIND_W)
    ) dec_i (
      .dst_i    (byp_dst_i[s*DST_W +: DST_W]),
      .kind_i   (byp_kind_i[s*KIND_W +: KIND_W]),
      .ext_wr_o (stg_ext[s]),
      .hit_o    (stg_hit[s])
    );
  end

  always_comb begin
    for (int r = 0; r < NUM_REGS; r++) begin
      for (int s = 0; s < NUM_STAGES; s++) begin
        reg_hit[r][s] = stg_hit[s][r];
      end
    end
  end

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_word
    fwd_word_pick #(
      .WORD_W     (WORD_W),
      .NUM_STAGES (NUM_STAGES)
    ) pick_i (
      .stored_i (st_regs_i[r*WORD_W +: WORD_W]),
      .hit_i    (reg_hit[r]),
      .vals_i   (byp_val_i),
      .word_o   (fwd_word[r])
    );
  end

  fwd_blk_merge #(
    .WORD_W (WORD_W)
  ) merge_i (
    .res_vld_i (res_vld_i),
    .res_blk_i (res_blk_i),
    .hi_i      (fwd_word[fwd_pkg::HI_IDX]),
    .lo_i      (fwd_word[fwd_pkg::LO_IDX]),
    .blk_o     (blk_o)
  );

  for (genvar k = 0; k < NUM_KEY; k++) begin : g_key
    assign key_o[k*WORD_W +: WORD_W] = fwd_word[fwd_pkg::KEY_BASE + k];
  end

  assign ext_dst_o = stg_ext;

endmodule

// File: rtl/ext_fwd_unit_chk.sv
`timescale 1ns/1ps
module ext_fwd_unit_chk #(
  parameter int WORD_W     = 32,
  parameter int NUM_STAGES = 3,
  parameter int NUM_REGS   = 6,
  parameter int DST_W      = 5,
  parameter int ADDR_W     = 4,
  parameter int KIND_W     = 3
) (
  input logic [NUM_REGS*WORD_W-1:0]     st_regs_i,
  input logic [NUM_STAGES*DST_W-1:0]    byp_dst_i,
  input logic [NUM_STAGES*WORD_W-1:0]   byp_val_i,
  input logic [NUM_STAGES*KIND_W-1:0]   byp_kind_i,
  input logic                           res_vld_i,
  input logic [2*WORD_W-1:0]            res_blk_i,
  input logic [2*WORD_W-1:0]            blk_o,
  input logic [(NUM_REGS-2)*WORD_W-1:0] key_o,
  input logic [NUM_STAGES-1:0]          ext_dst_o
);

  logic [NUM_STAGES-1:0] q_src;
  logic [NUM_STAGES-1:0] q_low;
  logic                  quiet;

  always_comb begin
    for (int s = 0; s < NUM_STAGES; s++) begin
      q_src[s] = (byp_kind_i[s*KIND_W +: KIND_W] == KIND_W'(1)) ||
                 (byp_kind_i[s*KIND_W +: KIND_W] == KIND_W'(2));
      q_low[s] = q_src[s] &&
                 (int'(byp_dst_i[s*DST_W +: ADDR_W]) < NUM_REGS);
    end
    quiet = !res_vld_i && (q_low == '0);
  end

  always_comb begin
    if (quiet) begin
      AST_QUIET_PASS: assert ((blk_o == {st_regs_i[0 +: WORD_W], st_regs_i[WORD_W +: WORD_W]}) &&
                              (key_o == st_regs_i[NUM_REGS*WORD_W-1:2*WORD_W]))
        else $error("stored words not passed through"); // R4
    end
    if (res_vld_i) begin
      AST_RES_OVERRIDE: assert (blk_o == res_blk_i)
        else $error("result bypass not applied"); // R6
    end
    for (int r = 2; r < NUM_REGS; r++) begin
      if (q_src[0] && (int'(byp_dst_i[0 +: ADDR_W]) == r)) begin
        AST_EX_YOUNGEST: assert (key_o[(r-2)*WORD_W +: WORD_W] == byp_val_i[0 +: WORD_W])
          else $error("execute-stage bypass lost"); // R5
      end
    end
    for (int s = 0; s < NUM_STAGES; s++) begin
      AST_EXT_FLAG: assert (ext_dst_o[s] == q_src[s])
        else $error("extension destination flag wrong"); // R7
    end
  end

endmodule

bind ext_fwd_unit ext_fwd_unit_chk #(
  .WORD_W     (WORD_W),
  .NUM_STAGES (NUM_STAGES),
  .NUM_REGS   (NUM_REGS),
  .DST_W      (DST_W),
  .ADDR_W     (ADDR_W),
  .KIND_W     (KIND_W)
) chk_i (
  .st_regs_i  (st_regs_i),
  .byp_dst_i  (byp_dst_i),
  .byp_val_i  (byp_val_i),
  .byp_kind_i (byp_kind_i),
  .res_vld_i  (res_vld_i),
  .res_blk_i  (res_blk_i),
  .blk_o      (blk_o),
  .key_o      (key_o),
  .ext_dst_o  (ext_dst_o)
);

// File: tb/ext_fwd_unit_tb.sv
`timescale 1ns/1ps
module ext_fwd_unit_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WDOG_LIMIT = 150000;

  logic clk;
  logic rst_n;

  logic [191:0] st_regs_i;
  logic [14:0]  byp_dst_i;
  logic [95:0]  byp_val_i;
  logic [8:0]   byp_kind_i;
  logic         res_vld_i;
  logic [63:0]  res_blk_i;
  logic [63:0]  blk_o;
  logic [127:0] key_o;
  logic [2:0]   ext_dst_o;

  logic [31:0] st   [6];
  logic [4:0]  dst  [3];
  logic [31:0] val  [3];
  logic [2:0]  kind [3];
  logic        rv;
  logic [63:0] rb;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;
  int cyc    = 0;

  ext_fwd_unit dut_i (
    .st_regs_i  (st_regs_i),
    .byp_dst_i  (byp_dst_i),
    .byp_val_i  (byp_val_i),
    .byp_kind_i (byp_kind_i),
    .res_vld_i  (res_vld_i),
    .res_blk_i  (res_blk_i),
    .blk_o      (blk_o),
    .key_o      (key_o),
    .ext_dst_o  (ext_dst_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  always @(posedge clk) begin
    if (!done && cyc > WDOG_LIMIT) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual cycle %0d expected below %0d", cyc, WDOG_LIMIT);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  function automatic bit fwd_kind(input logic [2:0] k);
    return (k == 3'd1) || (k == 3'd2);
  endfunction

  task automatic drive();
    for (int r = 0; r < 6; r++) st_regs_i[r*32 +: 32] = st[r];
    for (int s = 0; s < 3; s++) begin
      byp_dst_i[s*5 +: 5]  = dst[s];
      byp_val_i[s*32 +: 32] = val[s];
      byp_kind_i[s*3 +: 3] = kind[s];
    end
    res_vld_i = rv;
    res_blk_i = rb;
  endtask

  // Model: for each word, scan youngest stage first and take the first hit.
  task automatic check(input string tag);
    logic [31:0]  w [6];
    logic [63:0]  eb;
    logic [127:0] ek;
    logic [2:0]   em;
    for (int r = 0; r < 6; r++) begin
      bit found = 0;
      w[r] = st[r];
      for (int s = 0; s < 3; s++) begin
        if (!found && fwd_kind(kind[s]) && (dst[s] % 16 == r)) begin
          w[r]  = val[s];
          found = 1;
        end
      end
    end
    eb = rv ? rb : {w[0], w[1]};
    ek = {w[5], w[4], w[3], w[2]};
    for (int s = 0; s < 3; s++) em[s] = fwd_kind(kind[s]);
    n_chk++;
    if (blk_o !== eb || key_o !== ek || ext_dst_o !== em) begin
      n_fail++;
      $display("FAIL %s: actual blk=%h key=%h flag=%b expected blk=%h key=%h flag=%b",
               tag, blk_o, key_o, ext_dst_o, eb, ek, em);
    end
  endtask

  task automatic idle_buses();
    for (int s = 0; s < 3; s++) begin
      dst[s] = 5'd0; kind[s] = 3'd0; val[s] = 32'hDEAD_0000 + s;
    end
    rv = 1'b0;
    rb = 64'h0123_4567_89AB_CDEF;
  endtask

  initial begin
    rst_n = 1'b0;
    for (int r = 0; r < 6; r++) st[r] = 32'h5100_0000 + 32'(r) * 32'h0011_0101;
    idle_buses();
    drive();
    #(CLK_PERIOD*2);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: idle buses pass stored words
    drive(); #1; check("R1");

    // R2 R3 R4 R5 R7: one stage at a time, every kind and destination field
    for (int s = 0; s < 3; s++) begin
      for (int k = 0; k < 8; k++) begin
        for (int d = 0; d < 32; d++) begin
          idle_buses();
          kind[s] = 3'(k);
          dst[s]  = 5'(d);
          val[s]  = 32'hA000_0000 | (32'(s) << 16) | (32'(k) << 8) | 32'(d);
          drive(); #1;
          if (!fwd_kind(3'(k)))  check("R2");
          else if (d >= 16)      check("R3");
          else if (d % 16 >= 6)  check("R4");
          else                   check("R7");
        end
      end
    end

    // R5: all stages active with overlapping targets
    for (int k0 = 0; k0 < 4; k0++)
      for (int k1 = 0; k1 < 4; k1++)
        for (int k2 = 0; k2 < 4; k2++)
          for (int d0 = 0; d0 < 6; d0++)
            for (int d1 = 0; d1 < 6; d1++)
              for (int d2 = 0; d2 < 6; d2++) begin
                idle_buses();
                kind[0] = 3'(k0); kind[1] = 3'(k1); kind[2] = 3'(k2);
                dst[0] = 5'(d0); dst[1] = 5'(d1 + 16); dst[2] = 5'(d2);
                val[0] = 32'hE000_0000 + 32'(d0);
                val[1] = 32'hB000_0000 + 32'(d1);
                val[2] = 32'hC000_0000 + 32'(d2);
                drive(); #1; check("R5");
              end

    // R6: result bypass against stage writes to every word
    for (int d = 0; d < 6; d++) begin
      for (int s = 0; s < 3; s++) begin
        idle_buses();
        kind[s] = 3'd1;
        dst[s]  = 5'(d);
        val[s]  = 32'h7700_0000 + 32'(d);
        rv = 1'b1;
        rb = {32'hF00D_0000 + 32'(s), 32'hBEEF_0000 + 32'(d)};
        drive(); #1; check("R6");
      end
    end

    // R8: change right after an edge, observe before the next edge
    @(posedge clk); #1;
    idle_buses();
    kind[2] = 3'd2; dst[2] = 5'd3; val[2] = 32'h0808_0808;
    drive(); #1; check("R8");
    rv = 1'b1; rb = 64'hCAFE_F00D_1234_5678;
    drive(); #1; check("R8");

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule